// File: doc/BRIEF.md
# Power Ring Qualifier with Power-Mode Control

This block decides whether a telephone line is carrying a genuine power ring. Its input is a single digital level, already rectified and thresholded upstream, that is high while the ring voltage is above the detection threshold. Two slow strobes pace an up/down integrator. While the level is high, the fast strobe counts the integrator up. While the level is low, the slow strobe counts it down, at half the fast rate. Two thresholds give hysteresis. The ring is declared present once the count reaches the upper threshold. It is declared absent once the count falls back to the lower threshold.

A small power-mode controller sits alongside the integrator. It turns a power-down request and a ring-timing level into one of three modes: sleeping, partially awake or fully awake. The integrator works only in the two awake modes. In the sleeping mode it is held empty, and its detect output is held inactive.

Top module: `ring_qual_top`

## Requirements
- R1: `pwr_mode_o` follows the inputs one clock later. With `pwr_down_req_i`=1 and `ring_timer_i`=1 it is 0 (sleep). With `pwr_down_req_i`=1 and `ring_timer_i`=0 it is 1 (partial). With `pwr_down_req_i`=0 it is 2 (full), whatever `ring_timer_i` is.
- R2: In partial or full mode, every clock with `ring_lvl_i`=1 and `tick_up_i`=1 adds one to the count.
- R3: In partial or full mode, every clock with `ring_lvl_i`=0 and `tick_dn_i`=1 subtracts one from the count.
- R4: When both strobes arrive in the same clock, only the strobe that matches `ring_lvl_i` acts. The other strobe is ignored.
- R5: One clock after the count reaches 48 or more, `ring_det_n_o` goes low (active).
- R6: One clock after the count falls to 32 or less, `ring_det_n_o` goes high (inactive).
- R7: While the count lies between 33 and 47, `ring_det_n_o` keeps its previous value.
- R8: The count saturates at 63 and at 0. It never wraps.
- R9: While the mode is sleep, the count is cleared to 0 and `ring_det_n_o` is forced high.
- R10: Synchronous reset sets the mode to sleep, the count to 0 and `ring_det_n_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_lvl_i | input | 1 | Thresholded ring level, high while the ring voltage is above the threshold |
| tick_up_i | input | 1 | One-clock strobe at the fast (800 Hz) rate |
| tick_dn_i | input | 1 | One-clock strobe at the slow (400 Hz) rate |
| pwr_down_req_i | input | 1 | Power-down request, active high |
| ring_timer_i | input | 1 | Ring-timing level. It picks sleep or partial while power-down is requested |
| ring_det_n_o | output | 1 | Ring qualified, active low |
| pwr_mode_o | output | 2 | Mode: 0 sleep, 1 partial, 2 full |

## Verification
Two pairs of functions can meet in the same clock. The first pair is the two counting strobes, which can coincide on one edge. The second pair is a pending detect decision and entry into sleep. The bench drives both strobes together under each input level, and checks that the release point comes exactly sixteen strobes after the set point. It also requests power-down while the detect output is active, then checks that the output is released and that a fresh run of 48 up-strobes is needed to qualify again.

// File: rtl/ring_qual_pkg.sv
package ring_qual_pkg;

    typedef enum logic [1:0] {
        PM_SLEEP   = 2'd0,
        PM_PARTIAL = 2'd1,
        PM_FULL    = 2'd2
    } pwr_mode_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_INC  = 2'd1,
        STEP_DEC  = 2'd2
    } step_e;

    localparam int unsigned DEF_CNT_W   = 6;
    localparam int unsigned DEF_QUAL_TH = 48;
    localparam int unsigned DEF_DISQ_TH = 32;

    function automatic pwr_mode_e decode_mode(input logic pd_req, input logic rtime);
        if (!pd_req)
            return PM_FULL;
        else if (rtime)
            return PM_SLEEP;
        else
            return PM_PARTIAL;
    endfunction

    // Only the strobe that agrees with the level counts.
    function automatic step_e pick_step(input logic lvl, input logic up, input logic dn);
        if (lvl && up)
            return STEP_INC;
        else if (!lvl && dn)
            return STEP_DEC;
        else
            return STEP_HOLD;
    endfunction

endpackage

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import ring_qual_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      pd_req,
    input  logic      rtime,
    output pwr_mode_e mode_q
);
    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= PM_SLEEP;
        else
            mode_q <= decode_mode(pd_req, rtime);
    end
endmodule

// File: rtl/ring_integrator.sv
module ring_integrator
    import ring_qual_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  step_e            step,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (!run)
            cnt_d = '0;
        else begin
            case (step)
                STEP_INC: if (cnt_q != CNT_TOP) cnt_d = cnt_q + CNT_ONE;
                STEP_DEC: if (cnt_q != '0)      cnt_d = cnt_q - CNT_ONE;
                default:  cnt_d = cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ring_hyst.sv
module ring_hyst
    import ring_qual_pkg::*;
#(
    parameter int unsigned CNT_W   = DEF_CNT_W,
    parameter int unsigned QUAL_TH = DEF_QUAL_TH,
    parameter int unsigned DISQ_TH = DEF_DISQ_TH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    output logic             det_q
);
    localparam logic [CNT_W-1:0] SET_LVL = CNT_W'(QUAL_TH);
    localparam logic [CNT_W-1:0] CLR_LVL = CNT_W'(DISQ_TH);

    always_ff @(posedge clk) begin
        if (rst || !run)
            det_q <= 1'b0;
        else if (cnt >= SET_LVL)
            det_q <= 1'b1;
        else if (cnt <= CLR_LVL)
            det_q <= 1'b0;
    end
endmodule

// File: rtl/ring_qual_top.sv
module ring_qual_top
    import ring_qual_pkg::*;
#(
    parameter int unsigned CNT_W   = DEF_CNT_W,
    parameter int unsigned QUAL_TH = DEF_QUAL_TH,
    parameter int unsigned DISQ_TH = DEF_DISQ_TH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ring_lvl_i,
    input  logic       tick_up_i,
    input  logic       tick_dn_i,
    input  logic       pwr_down_req_i,
    input  logic       ring_timer_i,
    output logic       ring_det_n_o,
    output logic [1:0] pwr_mode_o
);
    pwr_mode_e        mode_q;
    logic             run;
    step_e            step;
    logic [CNT_W-1:0] cnt_q;
    logic             det_q;

    pwr_mode_ctrl u_mode (
        .clk    (clk),
        .rst    (rst),
        .pd_req (pwr_down_req_i),
        .rtime  (ring_timer_i),
        .mode_q (mode_q)
    );

    assign run  = (mode_q != PM_SLEEP);
    assign step = pick_step(ring_lvl_i, tick_up_i, tick_dn_i);

    ring_integrator #(.CNT_W(CNT_W)) u_integ (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .step  (step),
        .cnt_q (cnt_q)
    );

    ring_hyst #(.CNT_W(CNT_W), .QUAL_TH(QUAL_TH), .DISQ_TH(DISQ_TH)) u_hyst (
        .clk   (clk),
        .rst   (rst),
        .run   (run),
        .cnt   (cnt_q),
        .det_q (det_q)
    );

    assign ring_det_n_o = ~det_q;
    assign pwr_mode_o   = mode_q;
endmodule

// File: rtl/ring_qual_chk.sv
module ring_qual_chk
    import ring_qual_pkg::*;
#(
    parameter int unsigned CNT_W   = DEF_CNT_W,
    parameter int unsigned QUAL_TH = DEF_QUAL_TH,
    parameter int unsigned DISQ_TH = DEF_DISQ_TH
) (
    input logic             clk,
    input logic             rst,
    input logic             lvl,
    input logic             tu,
    input logic             td,
    input logic             pd,
    input logic [CNT_W-1:0] cnt,
    input logic             det_n,
    input logic [1:0]       mode
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] SET_LVL = CNT_W'(QUAL_TH);
    localparam logic [CNT_W-1:0] CLR_LVL = CNT_W'(DISQ_TH);

    // R1
    full_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !pd |=> mode == 2'd2);

    // R2
    count_up_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd0 && lvl && tu && cnt != TOP) |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R3
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd0 && !lvl && td && cnt != '0) |=> cnt == CNT_W'($past(cnt) - 1'b1));

    // R4
    off_level_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd0 && lvl && !tu) |=> $stable(cnt));

    // R5
    qualify_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd0 && cnt >= SET_LVL) |=> !det_n);

    // R6
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd0 && cnt <= CLR_LVL) |=> det_n);

    // R7
    hold_band_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd0 && cnt > CLR_LVL && cnt < SET_LVL) |=> det_n == $past(det_n));

    // R8
    ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd0 && cnt == TOP) |=> cnt == TOP || cnt == CNT_W'(TOP - 1'b1));

    // R9
    sleep_clear_chk: assert property (@(posedge clk) disable iff (rst)
        mode == 2'd0 |=> cnt == '0 && det_n);
endmodule

bind ring_qual_top ring_qual_chk #(.CNT_W(CNT_W), .QUAL_TH(QUAL_TH), .DISQ_TH(DISQ_TH)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .lvl   (ring_lvl_i),
    .tu    (tick_up_i),
    .td    (tick_dn_i),
    .pd    (pwr_down_req_i),
    .cnt   (cnt_q),
    .det_n (ring_det_n_o),
    .mode  (pwr_mode_o)
);

// File: tb/ring_qual_top_bench.sv
`timescale 1ns/1ps
module ring_qual_top_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ring_lvl_i = 1'b0, tick_up_i = 1'b0, tick_dn_i = 1'b0;
    logic pwr_down_req_i = 1'b1, ring_timer_i = 1'b1;
    logic ring_det_n_o;
    logic [1:0] pwr_mode_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int m_mode = 0;
    int m_cnt  = 0;
    bit m_det  = 0;

    always #10 clk = ~clk;

    ring_qual_top u_ring_qual_top (
        .clk(clk), .rst(rst), .ring_lvl_i(ring_lvl_i), .tick_up_i(tick_up_i),
        .tick_dn_i(tick_dn_i), .pwr_down_req_i(pwr_down_req_i), .ring_timer_i(ring_timer_i),
        .ring_det_n_o(ring_det_n_o), .pwr_mode_o(pwr_mode_o)
    );

    function automatic int exp_mode(input bit pd, input bit rt);
        return pd ? (rt ? 0 : 1) : 2;
    endfunction

    function automatic int exp_cnt(input int c, input int md, input bit l, input bit u, input bit d);
        if (md == 0) return 0;
        if (l && u) return (c < 63) ? c + 1 : c;
        if (!l && d) return (c > 0) ? c - 1 : c;
        return c;
    endfunction

    function automatic bit exp_det(input int c, input int md, input bit dt);
        if (md == 0) return 0;
        if (c >= 48) return 1;
        if (c <= 32) return 0;
        return dt;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit l, input bit u, input bit d, input bit pd, input bit rt, input string tag);
        int nc;
        bit nd;
        ring_lvl_i = l; tick_up_i = u; tick_dn_i = d;
        pwr_down_req_i = pd; ring_timer_i = rt;
        @(posedge clk);
        nd = exp_det(m_cnt, m_mode, m_det);
        nc = exp_cnt(m_cnt, m_mode, l, u, d);
        m_det = nd; m_cnt = nc; m_mode = exp_mode(pd, rt);
        @(negedge clk);
        check({tag, " mode"}, int'(pwr_mode_o), m_mode);
        check({tag, " det"}, int'(ring_det_n_o), int'(!m_det));
    endtask

    task automatic repeat_step(input int n, input bit l, input bit u, input bit d, input string tag);
        for (int i = 0; i < n; i++) step(l, u, d, 1'b0, 1'b0, tag);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R10 reset mode", int'(pwr_mode_o), 0);
        check("R10 reset det", int'(ring_det_n_o), 1);
        rst = 1'b0;

        // R1 mode decode
        step(0, 0, 0, 1, 0, "R1 partial");
        check("R1 partial explicit", int'(pwr_mode_o), 1);
        step(0, 0, 0, 0, 1, "R1 full");
        check("R1 full explicit", int'(pwr_mode_o), 2);
        step(0, 0, 0, 1, 1, "R1 sleep");
        check("R1 sleep explicit", int'(pwr_mode_o), 0);
        step(0, 0, 0, 0, 0, "R1 full again");

        // R2 / R5: 47 ups is not enough, the 48th qualifies
        repeat_step(47, 1, 1, 0, "R2 up");
        step(1, 0, 0, 0, 0, "R5 hold at 47");
        check("R5 not yet at 47", int'(ring_det_n_o), 1);
        step(1, 1, 0, 0, 0, "R5 reach 48");
        step(1, 0, 0, 0, 0, "R5 hold");
        check("R5 qualified at 48", int'(ring_det_n_o), 0);

        // R3 / R7 / R6
        repeat_step(15, 0, 0, 1, "R3 down");
        step(0, 0, 0, 0, 0, "R7 hold");
        check("R7 held at 33", int'(ring_det_n_o), 0);
        step(0, 0, 1, 0, 0, "R6 reach 32");
        step(0, 0, 0, 0, 0, "R6 hold");
        check("R6 released at 32", int'(ring_det_n_o), 1);

        // R4 both strobes together
        repeat_step(16, 1, 1, 1, "R4 both high");
        step(1, 0, 0, 0, 0, "R4 hold");
        check("R4 level-high both strobes", int'(ring_det_n_o), 0);
        repeat_step(16, 0, 1, 1, "R4 both low");
        step(0, 0, 0, 0, 0, "R4 hold");
        check("R4 level-low both strobes", int'(ring_det_n_o), 1);

        // R8 ceiling and floor
        repeat_step(80, 1, 1, 0, "R8 pump");
        repeat_step(30, 0, 0, 1, "R8 drain");
        step(0, 0, 0, 0, 0, "R8 hold");
        check("R8 ceiling 33 still set", int'(ring_det_n_o), 0);
        step(0, 0, 1, 0, 0, "R8 to 32");
        step(0, 0, 0, 0, 0, "R8 hold");
        check("R8 ceiling release", int'(ring_det_n_o), 1);
        repeat_step(40, 0, 0, 1, "R8 floor");
        step(0, 0, 0, 0, 0, "R8 hold");
        check("R8 floor no wrap", int'(ring_det_n_o), 1);
        repeat_step(47, 1, 1, 0, "R8 refill");
        step(1, 0, 0, 0, 0, "R8 hold");
        check("R8 floor at 0", int'(ring_det_n_o), 1);
        step(1, 1, 0, 0, 0, "R8 48");
        step(1, 0, 0, 0, 0, "R8 hold");
        check("R8 floor qualifies at 48", int'(ring_det_n_o), 0);

        // R9 sleep clears
        step(1, 1, 0, 1, 1, "R9 enter sleep");
        step(1, 1, 0, 1, 1, "R9 sleeping");
        check("R9 det released", int'(ring_det_n_o), 1);
        step(1, 1, 0, 0, 0, "R9 wake");
        repeat_step(47, 1, 1, 0, "R9 refill");
        step(1, 0, 0, 0, 0, "R9 hold");
        check("R9 count was cleared", int'(ring_det_n_o), 1);

        // random traffic, R2 R3 R4 R1 R9 against the model
        for (int i = 0; i < 6000; i++) begin
            bit pd;
            pd = ($urandom % 50) == 0;
            step(($urandom % 8) < 5, ($urandom % 3) == 0, ($urandom % 5) == 0,
                 pd, ($urandom % 2) == 0, "R2 R3 random");
        end

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule